// File: doc/BRIEF.md
# Resistive Touch Panel Scan Sequencer

This block runs the measurement loop for a four-wire resistive touch panel. For every frame it steps through twelve conversion slots. For each slot it places a drive code on the panel bias switches, waits a programmable settling time, asks the ADC for one 10-bit conversion and stores the result. The most recent frame stays readable slot by slot through a select input.

At the end of each frame the block decides whether the pen is touching the panel. Two dedicated detect samples must both lie below a programmable threshold. If the pen is down, the block also outputs the mean of the four X samples and the mean of the four Y samples, together with a one-cycle valid strobe.

Slot roles, counted from 0:
- Slots 0, 1, 10 and 11 are detect measurements.
- Slots 0 and 10 only let the panel settle, and their values play no part in the decision.
- Slots 2 to 5 sample X.
- Slots 6 to 9 sample Y.

While scanning is enabled, frames run back to back. Analog biasing, the converter itself and any calibration math lie outside the block.

Top module: `touch_scan_top`

## Requirements
- R1: Each frame makes exactly 12 conversions. Conversion k (k = 0..11) is stored in slot k. After the frame, `sample_data` shows slot k when `sample_sel` = k, and shows 0 for select values 12 to 15. After reset, every slot reads 0.
- R2: `drive_cfg` carries the code for the slot in progress:
  - 4'h1 for slots 0, 1, 10 and 11;
  - 4'h2 for slots 2 to 5;
  - 4'h4 for slots 6 to 9;
  - 4'h0 while the sequencer is idle.
  It never has more than one bit set, and it is non-zero whenever `adc_req` is high.
- R3: Between the cycle in which a conversion completes (`adc_ready` seen high while `adc_req` is high) and the next request, `adc_req` stays low for exactly `settle_cycles`+1 cycles. A raised request stays high until `adc_ready`.
- R4: The pen is judged down exactly when slot 1 and slot 11 are both strictly below the threshold. A value equal to the threshold counts as up. Slots 0 and 10 have no influence on the decision.
- R5: `pen_down` changes only in the cycle after a frame's last conversion has been stored. It holds its value during a frame and while the sequencer is idle.
- R6: On a pen-down frame, `coord_x` becomes (slot2+slot3+slot4+slot5)>>2, `coord_y` becomes (slot6+slot7+slot8+slot9)>>2, and `coord_valid` pulses high for one cycle. On a pen-up frame there is no pulse and both coordinates keep their previous values.
- R7: The threshold resets to 750 and is visible on `thr_value`. A write with `thr_wr_data` in 0..1023 takes effect on the next clock. A write above 1023 is ignored and the old value is kept.
- R8: While `scan_en` is high at the end of a frame, the next frame starts at once. If `scan_en` is low at the end of a frame, the sequencer goes idle. Dropping `scan_en` in the middle of a frame still lets that frame complete.
- R9: After reset: `pen_down`, `coord_valid`, `coord_x`, `coord_y`, `adc_req` and `drive_cfg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Run frames while high |
| settle_cycles | input | 8 | Settling wait before each request, in cycles minus one |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | 16 | Threshold write value |
| thr_value | output | 10 | Current threshold |
| adc_req | output | 1 | Conversion request, held until ready |
| adc_ready | input | 1 | Conversion done, data valid |
| adc_data | input | 10 | Conversion result |
| drive_cfg | output | 4 | Panel drive code for the current slot |
| pen_down | output | 1 | Pen state from the last frame |
| coord_x | output | 10 | Averaged X coordinate |
| coord_y | output | 10 | Averaged Y coordinate |
| coord_valid | output | 1 | One-cycle strobe for new coordinates |
| sample_sel | input | 4 | Slot select for readback |
| sample_data | output | 10 | Stored sample of the selected slot |

## Verification
A slot counter that is out of step with the frame shows up within one conversion. It appears as a wrong `drive_cfg` code at the next request, and later as samples that read back in the wrong slots. A settle counter fault changes the low gap of `adc_req` at the very next slot. Faults in the threshold register or in the pen comparison surface one cycle after the frame ends, as a wrong `pen_down`, an unexpected or missing `coord_valid` pulse, or wrong coordinates.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int NUM_SLOTS  = 12;
    localparam int SLOT_IDX_W = 4;
    localparam int CFG_W      = 4;
    localparam int AVG_N      = 4;
    localparam int AVG_SHIFT  = 2;

    // Slot roles inside one frame; this order is the scan sequence.
    localparam logic [SLOT_IDX_W-1:0] SLOT_LAST = 4'd11;
    localparam logic [SLOT_IDX_W-1:0] PEN_A     = 4'd1;
    localparam logic [SLOT_IDX_W-1:0] PEN_B     = 4'd11;
    localparam logic [SLOT_IDX_W-1:0] X_FIRST   = 4'd2;
    localparam logic [SLOT_IDX_W-1:0] X_LAST    = 4'd5;
    localparam logic [SLOT_IDX_W-1:0] Y_FIRST   = 4'd6;
    localparam logic [SLOT_IDX_W-1:0] Y_LAST    = 4'd9;

    localparam logic [CFG_W-1:0] CFG_IDLE   = 4'h0;
    localparam logic [CFG_W-1:0] CFG_DETECT = 4'h1;
    localparam logic [CFG_W-1:0] CFG_X      = 4'h2;
    localparam logic [CFG_W-1:0] CFG_Y      = 4'h4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_e;

    function automatic logic [CFG_W-1:0] slot_cfg(input logic [SLOT_IDX_W-1:0] s);
        if (s >= X_FIRST && s <= X_LAST) begin
            return CFG_X;
        end else if (s >= Y_FIRST && s <= Y_LAST) begin
            return CFG_Y;
        end
        return CFG_DETECT;
    endfunction

endpackage

// File: rtl/tsc_seq.sv
module tsc_seq
    import tsc_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [SETTLE_W-1:0]   settle_cycles,
    input  logic                  adc_ready,
    output logic                  adc_req,
    output logic [CFG_W-1:0]      drive_cfg,
    output logic                  cap_en,
    output logic [SLOT_IDX_W-1:0] cap_slot,
    output logic                  frame_done
);

    typedef struct packed {
        seq_state_e              state;
        logic [SLOT_IDX_W-1:0]   slot;
        logic [SETTLE_W-1:0]     cnt;
        logic                    done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (enable) begin
                    seq_d.state = ST_SETTLE;
                    seq_d.slot  = '0;
                    seq_d.cnt   = '0;
                end
            end
            ST_SETTLE: begin
                if (seq_q.cnt >= settle_cycles) begin
                    seq_d.state = ST_CONV;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_CONV: begin
                if (adc_ready) begin
                    seq_d.cnt = '0;
                    if (seq_q.slot == SLOT_LAST) begin
                        seq_d.done  = 1'b1;
                        seq_d.slot  = '0;
                        seq_d.state = enable ? ST_SETTLE : ST_IDLE;
                    end else begin
                        seq_d.slot  = seq_q.slot + 1'b1;
                        seq_d.state = ST_SETTLE;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, slot: '0, cnt: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign adc_req    = (seq_q.state == ST_CONV);
    assign cap_en     = (seq_q.state == ST_CONV) && adc_ready;
    assign cap_slot   = seq_q.slot;
    assign frame_done = seq_q.done;
    assign drive_cfg  = (seq_q.state == ST_IDLE) ? CFG_IDLE : slot_cfg(seq_q.slot);

endmodule

// File: rtl/tsc_frame.sv
module tsc_frame
    import tsc_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cap_en,
    input  logic [SLOT_IDX_W-1:0]                cap_slot,
    input  logic [SAMPLE_W-1:0]                  cap_data,
    input  logic [SLOT_IDX_W-1:0]                rd_sel,
    output logic [SAMPLE_W-1:0]                  rd_data,
    output logic [NUM_SLOTS-1:0][SAMPLE_W-1:0]   samples
);

    logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] smp_d, smp_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign smp_d[g] = (cap_en && (cap_slot == SLOT_IDX_W'(g))) ? cap_data : smp_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign samples = smp_q;
    assign rd_data = (rd_sel <= SLOT_LAST) ? smp_q[rd_sel] : '0;

endmodule

// File: rtl/tsc_decide.sv
module tsc_decide
    import tsc_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int THR_IN_W  = 16,
    parameter int THR_RESET = 750
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 frame_done,
    input  logic [NUM_SLOTS-1:0][SAMPLE_W-1:0]   samples,
    input  logic                                 thr_wr_en,
    input  logic [THR_IN_W-1:0]                  thr_wr_data,
    output logic [SAMPLE_W-1:0]                  thr_value,
    output logic                                 pen_down,
    output logic [SAMPLE_W-1:0]                  coord_x,
    output logic [SAMPLE_W-1:0]                  coord_y,
    output logic                                 coord_valid
);

    localparam int SUM_W = SAMPLE_W + AVG_SHIFT;

    typedef struct packed {
        logic [SAMPLE_W-1:0] thr;
        logic                pen;
        logic [SAMPLE_W-1:0] x;
        logic [SAMPLE_W-1:0] y;
        logic                valid;
    } dec_t;

    dec_t dec_d, dec_q;
    logic [SUM_W-1:0] sum_x, sum_y;
    logic             wr_in_range;
    logic             pen_now;

    always_comb begin
        sum_x = '0;
        sum_y = '0;
        for (int i = 0; i < AVG_N; i++) begin
            sum_x = sum_x + SUM_W'(samples[int'(X_FIRST) + i]);
            sum_y = sum_y + SUM_W'(samples[int'(Y_FIRST) + i]);
        end
    end

    assign wr_in_range = ~|thr_wr_data[THR_IN_W-1:SAMPLE_W];
    assign pen_now     = (samples[PEN_A] < dec_q.thr) && (samples[PEN_B] < dec_q.thr);

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = 1'b0;
        if (thr_wr_en && wr_in_range) begin
            dec_d.thr = thr_wr_data[SAMPLE_W-1:0];
        end
        if (frame_done) begin
            dec_d.pen = pen_now;
            if (pen_now) begin
                dec_d.x     = sum_x[SUM_W-1:AVG_SHIFT];
                dec_d.y     = sum_y[SUM_W-1:AVG_SHIFT];
                dec_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '{thr: SAMPLE_W'(THR_RESET), pen: 1'b0, x: '0, y: '0, valid: 1'b0};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign thr_value   = dec_q.thr;
    assign pen_down    = dec_q.pen;
    assign coord_x     = dec_q.x;
    assign coord_y     = dec_q.y;
    assign coord_valid = dec_q.valid;

endmodule

// File: rtl/touch_scan_top.sv
module touch_scan_top
    import tsc_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int SETTLE_W  = 8,
    parameter int THR_IN_W  = 16,
    parameter int THR_RESET = 750
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_en,
    input  logic [SETTLE_W-1:0]   settle_cycles,
    input  logic                  thr_wr_en,
    input  logic [THR_IN_W-1:0]   thr_wr_data,
    output logic [SAMPLE_W-1:0]   thr_value,
    output logic                  adc_req,
    input  logic                  adc_ready,
    input  logic [SAMPLE_W-1:0]   adc_data,
    output logic [CFG_W-1:0]      drive_cfg,
    output logic                  pen_down,
    output logic [SAMPLE_W-1:0]   coord_x,
    output logic [SAMPLE_W-1:0]   coord_y,
    output logic                  coord_valid,
    input  logic [SLOT_IDX_W-1:0] sample_sel,
    output logic [SAMPLE_W-1:0]   sample_data
);

    logic                               cap_en;
    logic [SLOT_IDX_W-1:0]              cap_slot;
    logic                               frame_done;
    logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] frame_samples;

    tsc_seq #(
        .SETTLE_W (SETTLE_W)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (scan_en),
        .settle_cycles (settle_cycles),
        .adc_ready     (adc_ready),
        .adc_req       (adc_req),
        .drive_cfg     (drive_cfg),
        .cap_en        (cap_en),
        .cap_slot      (cap_slot),
        .frame_done    (frame_done)
    );

    tsc_frame #(
        .SAMPLE_W (SAMPLE_W)
    ) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_slot (cap_slot),
        .cap_data (adc_data),
        .rd_sel   (sample_sel),
        .rd_data  (sample_data),
        .samples  (frame_samples)
    );

    tsc_decide #(
        .SAMPLE_W  (SAMPLE_W),
        .THR_IN_W  (THR_IN_W),
        .THR_RESET (THR_RESET)
    ) i_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .samples     (frame_samples),
        .thr_wr_en   (thr_wr_en),
        .thr_wr_data (thr_wr_data),
        .thr_value   (thr_value),
        .pen_down    (pen_down),
        .coord_x     (coord_x),
        .coord_y     (coord_y),
        .coord_valid (coord_valid)
    );

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int SAMPLE_W = 10,
    parameter int THR_IN_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                adc_req,
    input logic                adc_ready,
    input logic [3:0]          drive_cfg,
    input logic                pen_down,
    input logic                coord_valid,
    input logic                frame_done,
    input logic                thr_wr_en,
    input logic [THR_IN_W-1:0] thr_wr_data,
    input logic [SAMPLE_W-1:0] thr_value
);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req && !adc_ready |=> adc_req);

    assert_cfg_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive_cfg));

    assert_cfg_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req |-> drive_cfg != 4'h0);

    assert_pen_at_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pen_down) |-> $past(frame_done));

    assert_valid_needs_pen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        coord_valid |-> pen_down);

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        coord_valid |=> !coord_valid);

    assert_thr_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr_en && (|thr_wr_data[THR_IN_W-1:SAMPLE_W]) |=> $stable(thr_value));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

bind touch_scan_top tsc_checker #(
    .SAMPLE_W (SAMPLE_W),
    .THR_IN_W (THR_IN_W)
) i_tsc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_req     (adc_req),
    .adc_ready   (adc_ready),
    .drive_cfg   (drive_cfg),
    .pen_down    (pen_down),
    .coord_valid (coord_valid),
    .frame_done  (frame_done),
    .thr_wr_en   (thr_wr_en),
    .thr_wr_data (thr_wr_data),
    .thr_value   (thr_value)
);

// File: tb/test_touch_scan_top.sv
module test_touch_scan_top;

    localparam int W  = 10;
    localparam int TW = 16;
    localparam int NV = 6;

    typedef struct packed {
        logic [TW-1:0]       thr;
        logic [0:11][W-1:0]  s;
        logic                pen;
    } vec_t;

    // threshold write, twelve slot values, expected pen state
    localparam vec_t TBL [NV] = '{
        '{16'd750,  '{10'd1023, 10'd1023, 10'd0, 10'd0, 10'd0, 10'd0,
                      10'd530, 10'd529, 10'd530, 10'd529, 10'd1023, 10'd1023}, 1'b0},
        '{16'd750,  '{10'd1023, 10'd676, 10'd92, 10'd103, 10'd101, 10'd102,
                      10'd855, 10'd919, 10'd922, 10'd922, 10'd1023, 10'd679}, 1'b1},
        '{16'd750,  '{10'd1000, 10'd600, 10'd10, 10'd20, 10'd30, 10'd40,
                      10'd50, 10'd60, 10'd70, 10'd80, 10'd900, 10'd750}, 1'b0},
        '{16'd500,  '{10'd1023, 10'd499, 10'd1023, 10'd1023, 10'd1023, 10'd1023,
                      10'd0, 10'd1, 10'd2, 10'd3, 10'd1023, 10'd499}, 1'b1},
        '{16'd1020, '{10'd0, 10'd1020, 10'd5, 10'd5, 10'd5, 10'd5,
                      10'd5, 10'd5, 10'd5, 10'd5, 10'd0, 10'd3}, 1'b0},
        '{16'd2000, '{10'd1023, 10'd1019, 10'd4, 10'd8, 10'd12, 10'd16,
                      10'd100, 10'd200, 10'd300, 10'd401, 10'd1023, 10'd0}, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          scan_en;
    logic [7:0]    settle_cycles;
    logic          thr_wr_en;
    logic [TW-1:0] thr_wr_data;
    logic [W-1:0]  thr_value;
    logic          adc_req;
    logic          adc_ready;
    logic [W-1:0]  adc_data;
    logic [3:0]    drive_cfg;
    logic          pen_down;
    logic [W-1:0]  coord_x;
    logic [W-1:0]  coord_y;
    logic          coord_valid;
    logic [3:0]    sample_sel;
    logic [W-1:0]  sample_data;

    always #10 clk = ~clk;

    touch_scan_top i_touch_scan_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_en       (scan_en),
        .settle_cycles (settle_cycles),
        .thr_wr_en     (thr_wr_en),
        .thr_wr_data   (thr_wr_data),
        .thr_value     (thr_value),
        .adc_req       (adc_req),
        .adc_ready     (adc_ready),
        .adc_data      (adc_data),
        .drive_cfg     (drive_cfg),
        .pen_down      (pen_down),
        .coord_x       (coord_x),
        .coord_y       (coord_y),
        .coord_valid   (coord_valid),
        .sample_sel    (sample_sel),
        .sample_data   (sample_data)
    );

    int errors = 0;
    int checks = 0;
    int cur_vec = 0;
    int settle_now = 3;
    int conv_total = 0;
    int mslot = 0;
    int gap = 0;
    int valid_pulses = 0;
    int exp_thr, exp_x, exp_y, exp_pulses;
    logic exp_pen;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_cfg(input int k);
        if (k >= 2 && k <= 5) return 2;
        if (k >= 6 && k <= 9) return 4;
        return 1;
    endfunction

    function automatic int avg4(input int v, input int first);
        int sum = 0;
        for (int k = 0; k < 4; k++) sum += int'(TBL[v].s[first + k]);
        return sum >> 2;
    endfunction

    // ADC model and strobe monitor, all on the falling edge
    initial begin
        adc_ready = 1'b0;
        adc_data  = '0;
        forever begin
            @(negedge clk);
            gap++;
            if (coord_valid) valid_pulses++;
            if (adc_ready) begin
                adc_ready = 1'b0;
            end else if (adc_req) begin
                check(int'(drive_cfg) == exp_cfg(mslot), "R2 drive code", int'(drive_cfg), exp_cfg(mslot));
                if (mslot != 0) check(gap == settle_now + 2, "R3 settle gap", gap, settle_now + 2);
                adc_data  = TBL[cur_vec].s[mslot];
                adc_ready = 1'b1;
                gap       = 0;
                mslot     = (mslot + 1) % 12;
                conv_total++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", conv_total, -1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic write_thr(input logic [TW-1:0] v);
        @(negedge clk);
        thr_wr_data = v;
        thr_wr_en   = 1'b1;
        @(negedge clk);
        thr_wr_en   = 1'b0;
        if (v <= 1023) exp_thr = int'(v);
        check(int'(thr_value) == exp_thr, "R7 threshold", int'(thr_value), exp_thr);
    endtask

    // runs one frame with scan_en dropped after the first conversion
    task automatic run_frame(input int v);
        int base;
        cur_vec = v;
        base    = conv_total;
        scan_en = 1'b1;
        while (conv_total < base + 1) @(negedge clk);
        scan_en = 1'b0;
        while (conv_total < base + 12) @(negedge clk);
        check(pen_down == exp_pen, "R5 pen held in frame", int'(pen_down), int'(exp_pen));
        repeat (5) @(negedge clk);
        check(!adc_req && conv_total == base + 12, "R8 stop after frame", conv_total, base + 12);
        check(drive_cfg == 4'h0, "R2 idle code", int'(drive_cfg), 0);
    endtask

    task automatic check_result(input int v);
        exp_pen = TBL[v].pen;
        if (exp_pen) begin
            exp_x = avg4(v, 2);
            exp_y = avg4(v, 6);
            exp_pulses++;
        end
        check(pen_down == exp_pen, "R4 pen decision", int'(pen_down), int'(exp_pen));
        check(valid_pulses == exp_pulses, "R6 valid pulses", valid_pulses, exp_pulses);
        check(int'(coord_x) == exp_x, "R6 coord x", int'(coord_x), exp_x);
        check(int'(coord_y) == exp_y, "R6 coord y", int'(coord_y), exp_y);
        for (int k = 0; k < 12; k++) begin
            sample_sel = 4'(k);
            #1;
            check(sample_data == TBL[v].s[k], "R1 readback", int'(sample_data), int'(TBL[v].s[k]));
        end
    endtask

    initial begin
        int base;
        rst_n         = 1'b0;
        scan_en       = 1'b0;
        settle_cycles = 8'd3;
        thr_wr_en     = 1'b0;
        thr_wr_data   = '0;
        sample_sel    = '0;
        exp_thr = 750; exp_x = 0; exp_y = 0; exp_pulses = 0; exp_pen = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check(!pen_down && !coord_valid, "R9 pen/valid", int'(pen_down), 0);
        check(coord_x == 0 && coord_y == 0, "R9 coords", int'(coord_x), 0);
        check(!adc_req && drive_cfg == 0, "R9 req/cfg", int'(drive_cfg), 0);
        check(int'(thr_value) == 750, "R7 reset threshold", int'(thr_value), 750);
        for (int k = 0; k < 12; k++) begin
            sample_sel = 4'(k);
            #1;
            check(sample_data == 0, "R1 reset samples", int'(sample_data), 0);
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            write_thr(TBL[i].thr);
            run_frame(i);
            check_result(i);
        end

        // R8 continuous scanning across two frames
        base    = conv_total;
        cur_vec = 1;
        scan_en = 1'b1;
        while (conv_total < base + 14) @(negedge clk);
        check(valid_pulses == exp_pulses + 1, "R8 first back-to-back frame", valid_pulses, exp_pulses + 1);
        scan_en = 1'b0;
        while (conv_total < base + 24) @(negedge clk);
        repeat (5) @(negedge clk);
        exp_pulses++;
        check(conv_total == base + 24 && !adc_req, "R8 stopped after second frame", conv_total, base + 24);
        check_result(1);

        // R3 zero settle
        settle_cycles = 8'd0;
        settle_now    = 0;
        run_frame(0);
        check_result(0);

        // R7 boundaries: 1024 ignored, 1023 accepted; R4 equality counts as up
        write_thr(16'd1024);
        write_thr(16'd1023);
        run_frame(0);
        check_result(0);

        // R1 select beyond the last slot
        for (int k = 12; k < 16; k++) begin
            sample_sel = 4'(k);
            #1;
            check(sample_data == 0, "R1 select out of range", int'(sample_data), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule